// File: doc/BRIEF.md
# Scoreboarded Round-Robin Warp Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded shader core. It keeps one pending instruction per resident warp. A fill port writes one fetched instruction per cycle into the slot of its warp. Each fill carries an opaque opcode, one destination register tag and a set of source register tags. A per-warp scoreboard records which registers still wait for a result. A writeback port clears those marks when the values arrive.

At every issue opportunity the scheduler considers only warps whose buffered instruction names no busy register. It picks one of them in rotating order. It then marks that instruction's destination busy, frees the warp's slot and presents the instruction on a registered issue port. A warp of threads is swept across a narrower set of lanes, so each issue keeps the lanes occupied for several cycles. No new issue starts until that sweep is over.

Top module: `warp_issue_sched`

## Requirements
- R1: A fill whose warp slot is empty stores the instruction. A fill whose warp slot already holds an instruction is ignored, and the stored instruction is kept unchanged.
- R2: Each issue presents exactly one warp, with that warp's stored opcode and destination tag, and empties the warp's slot so that the next fill to it is accepted.
- R3: A warp may be selected only when its destination tag and every source tag are clear in that warp's own scoreboard.
- R4: A writeback clears one register of one warp only. The cleared bit takes part in selection from the cycle after the writeback edge, so with idle lanes the unblocked warp issues one edge after the writeback edge.
- R5: Among eligible warps, the search starts at the warp after the one issued last and wraps past the highest warp index to warp 0. After reset the search starts at warp 0.
- R6: Issues are spaced by at least WARP_THREADS/LANES cycles, which is 4 by default. A warp that is eligible when the lanes free up issues exactly that many cycles after the previous issue.
- R7: All NUM_WARPS warps, 24 by default, can hold instructions at the same time, and each of them is issued.
- R8: At issue, the destination register of the chosen warp becomes busy. A later instruction of that warp that reads or writes it waits for a writeback.
- R9: When a writeback and an issue name the same warp and register in the same cycle, the register ends up busy.
- R10: After reset all slots are empty, the scoreboard is clear and issue_valid is low.
- R11: With idle lanes, an instruction filled into an empty slot with clear operands appears on the issue port one edge after the fill edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill request this cycle |
| fill_warp | input | WID_W | Warp slot to fill |
| fill_op | input | OP_W | Opaque instruction payload |
| fill_dst | input | TAG_W | Destination register tag |
| fill_src | input | NUM_SRC*TAG_W | Source tags, source 0 in the low bits |
| wb_valid | input | 1 | Writeback of a result this cycle |
| wb_warp | input | WID_W | Warp of the written register |
| wb_reg | input | TAG_W | Register tag written back |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_op | output | OP_W | Payload of the issued instruction |
| issue_dst | output | TAG_W | Destination tag of the issued instruction |

## Verification
The bench builds the default configuration: 24 warps, 16 registers per warp, two sources, and 32 threads over 8 lanes. That gives a four-cycle sweep, which is long enough for two further fills to land while the lanes are held. The case where a later, higher-numbered warp is picked before a lower one therefore really occurs, and rotating order can be told apart from fixed priority. A full-occupancy run fills all 24 slots one per cycle while issues drain them every fourth cycle, which exercises both the wrap and the exact spacing.

// File: rtl/ws_pkg.sv
package ws_pkg;

   // width of an index able to address n items, never below one bit
   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // occupancy state of the execution lanes
   typedef enum logic {
      LANE_IDLE  = 1'b0,
      LANE_SWEEP = 1'b1
   } lane_state_e;

endpackage

// File: rtl/ws_slot_buf.sv
module ws_slot_buf
   import ws_pkg::*;
#(
   parameter int NW   = 24,
   parameter int OPW  = 16,
   parameter int TAGW = 4,
   parameter int NSRC = 2,
   localparam int WIDW = bits_for(NW),
   localparam int SRCW = NSRC * TAGW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_en,
   input  logic [WIDW-1:0]      fill_warp,
   input  logic [OPW-1:0]       fill_op,
   input  logic [TAGW-1:0]      fill_dst,
   input  logic [SRCW-1:0]      fill_src,
   input  logic                 clr_en,
   input  logic [WIDW-1:0]      clr_warp,
   output logic [NW-1:0]        q_vld,
   output logic [NW*OPW-1:0]    q_op,
   output logic [NW*TAGW-1:0]   q_dst,
   output logic [NW*SRCW-1:0]   q_src
);

   for (genvar g = 0; g < NW; g++) begin : g_slot
      logic hit_fill;
      logic hit_clr;
      assign hit_fill = fill_en && (fill_warp == WIDW'(g));
      assign hit_clr  = clr_en  && (clr_warp  == WIDW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_vld[g]                  <= 1'b0;
            q_op[g*OPW +: OPW]        <= '0;
            q_dst[g*TAGW +: TAGW]     <= '0;
            q_src[g*SRCW +: SRCW]     <= '0;
         end else if (hit_clr) begin
            q_vld[g] <= 1'b0;
         end else if (hit_fill && !q_vld[g]) begin
            q_vld[g]                  <= 1'b1;
            q_op[g*OPW +: OPW]        <= fill_op;
            q_dst[g*TAGW +: TAGW]     <= fill_dst;
            q_src[g*SRCW +: SRCW]     <= fill_src;
         end
      end
   end

   logic fill_in_range;
   logic clr_in_range;
   assign fill_in_range = {1'b0, fill_warp} < (WIDW+1)'(NW);
   assign clr_in_range  = {1'b0, clr_warp}  < (WIDW+1)'(NW);

   // R2: only a live slot is ever released, and it is empty afterwards
   p_clr_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> (clr_in_range && q_vld[clr_warp]));
   p_clr_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_in_range) |=> !q_vld[$past(clr_warp)]);

   // R1: a fill into an occupied slot leaves its payload untouched
   p_fill_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_in_range && q_vld[fill_warp] && !clr_en)
      |=> (q_vld[$past(fill_warp)] &&
           q_op[$past(fill_warp)*OPW +: OPW] == $past(q_op[fill_warp*OPW +: OPW])));

endmodule

// File: rtl/ws_scoreboard.sv
module ws_scoreboard
   import ws_pkg::*;
#(
   parameter int NW   = 24,
   parameter int NREG = 16,
   parameter int NSRC = 2,
   localparam int WIDW = bits_for(NW),
   localparam int TAGW = bits_for(NREG),
   localparam int SRCW = NSRC * TAGW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [WIDW-1:0]      set_warp,
   input  logic [TAGW-1:0]      set_reg,
   input  logic                 clr_en,
   input  logic [WIDW-1:0]      clr_warp,
   input  logic [TAGW-1:0]      clr_reg,
   input  logic [NW*TAGW-1:0]   q_dst,
   input  logic [NW*SRCW-1:0]   q_src,
   output logic [NW-1:0]        ops_ready
);

   logic [NREG-1:0] busy_q [NW];
   logic [NREG-1:0] busy_d [NW];

   for (genvar g = 0; g < NW; g++) begin : g_warp
      logic own_set;
      logic own_clr;
      assign own_set = set_en && (set_warp == WIDW'(g));
      assign own_clr = clr_en && (clr_warp == WIDW'(g));

      // clear first, then set: an issue wins over a same-cycle writeback
      always_comb begin
         busy_d[g] = busy_q[g];
         if (own_clr) busy_d[g][clr_reg] = 1'b0;
         if (own_set) busy_d[g][set_reg] = 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) busy_q[g] <= '0;
         else        busy_q[g] <= busy_d[g];
      end

      // operand check: destination plus each source
      always_comb begin
         ops_ready[g] = !busy_q[g][q_dst[g*TAGW +: TAGW]];
         for (int s = 0; s < NSRC; s++) begin
            if (busy_q[g][q_src[g*SRCW + s*TAGW +: TAGW]]) ops_ready[g] = 1'b0;
         end
      end
   end

   logic clr_in_range;
   logic same_reg;
   assign clr_in_range = {1'b0, clr_warp} < (WIDW+1)'(NW);
   assign same_reg     = set_en && clr_en && (set_warp == clr_warp) && (set_reg == clr_reg);

   // R3: the issued destination was free when it was chosen
   p_set_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !busy_q[set_warp][set_reg]);

   // R8: the issued destination is busy afterwards
   p_set_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> busy_q[$past(set_warp)][$past(set_reg)]);

   // R4: a writeback without a colliding issue frees its register
   p_wb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_in_range && !same_reg) |=> !busy_q[$past(clr_warp)][$past(clr_reg)]);

   // R9: the colliding case keeps the register busy
   p_collide_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      same_reg |=> busy_q[$past(set_warp)][$past(set_reg)]);

endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick
   import ws_pkg::*;
#(
   parameter int NW = 24,
   localparam int WIDW = bits_for(NW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    req,
   input  logic             adv,
   output logic             gnt_vld,
   output logic [WIDW-1:0]  gnt_idx
);

   logic [WIDW-1:0] ptr_q;

   // search forward from the pointer, wrapping past the top index
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < NW; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= NW) j = j - NW;
         if (!gnt_vld && req[j]) begin
            gnt_vld = 1'b1;
            gnt_idx = WIDW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv && gnt_vld) begin
         if (gnt_idx == WIDW'(NW-1)) ptr_q <= '0;
         else                        ptr_q <= gnt_idx + WIDW'(1);
      end
   end

   // R5: a grant always names a requester, and a requester is never passed over entirely
   p_grant_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> req[gnt_idx]);
   p_grant_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> gnt_vld);
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ptr_q} < (WIDW+1)'(NW));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import ws_pkg::*;
#(
   parameter int NUM_WARPS     = 24,
   parameter int REGS_PER_WARP = 16,
   parameter int NUM_SRC       = 2,
   parameter int OP_W          = 16,
   parameter int WARP_THREADS  = 32,
   parameter int LANES         = 8,
   localparam int WID_W = bits_for(NUM_WARPS),
   localparam int TAG_W = bits_for(REGS_PER_WARP),
   localparam int SRC_W = NUM_SRC * TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [WID_W-1:0]  fill_warp,
   input  logic [OP_W-1:0]   fill_op,
   input  logic [TAG_W-1:0]  fill_dst,
   input  logic [SRC_W-1:0]  fill_src,
   input  logic              wb_valid,
   input  logic [WID_W-1:0]  wb_warp,
   input  logic [TAG_W-1:0]  wb_reg,
   output logic              issue_valid,
   output logic [WID_W-1:0]  issue_warp,
   output logic [OP_W-1:0]   issue_op,
   output logic [TAG_W-1:0]  issue_dst
);

   localparam int SWEEP = (LANES > 0) ? WARP_THREADS / LANES : 1;
   localparam int CNT_W = bits_for(SWEEP);
   localparam int GAP_W = bits_for(SWEEP + 1);

   // elaboration-time parameter checks
   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("warp_issue_sched: NUM_WARPS must be at least 2");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("warp_issue_sched: NUM_SRC must be at least 1");
   end
   if (REGS_PER_WARP < 2 || (REGS_PER_WARP & (REGS_PER_WARP - 1)) != 0) begin : g_bad_regs
      $error("warp_issue_sched: REGS_PER_WARP must be a power of two");
   end
   if (LANES < 1 || WARP_THREADS < LANES || (WARP_THREADS % LANES) != 0) begin : g_bad_lanes
      $error("warp_issue_sched: WARP_THREADS must be a multiple of LANES");
   end

   logic [NUM_WARPS-1:0]        slot_vld;
   logic [NUM_WARPS*OP_W-1:0]   slot_op;
   logic [NUM_WARPS*TAG_W-1:0]  slot_dst;
   logic [NUM_WARPS*SRC_W-1:0]  slot_src;
   logic [NUM_WARPS-1:0]        ops_ready;
   logic [NUM_WARPS-1:0]        eligible;
   logic                        gnt_vld;
   logic [WID_W-1:0]            gnt_idx;
   logic                        lane_free;
   logic                        take;
   logic [TAG_W-1:0]            take_dst;

   assign eligible = slot_vld & ops_ready;
   assign take     = lane_free && gnt_vld;
   assign take_dst = slot_dst[gnt_idx*TAG_W +: TAG_W];

   ws_slot_buf #(
      .NW   (NUM_WARPS),
      .OPW  (OP_W),
      .TAGW (TAG_W),
      .NSRC (NUM_SRC)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_valid),
      .fill_warp (fill_warp),
      .fill_op   (fill_op),
      .fill_dst  (fill_dst),
      .fill_src  (fill_src),
      .clr_en    (take),
      .clr_warp  (gnt_idx),
      .q_vld     (slot_vld),
      .q_op      (slot_op),
      .q_dst     (slot_dst),
      .q_src     (slot_src)
   );

   ws_scoreboard #(
      .NW   (NUM_WARPS),
      .NREG (REGS_PER_WARP),
      .NSRC (NUM_SRC)
   ) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (take),
      .set_warp  (gnt_idx),
      .set_reg   (take_dst),
      .clr_en    (wb_valid),
      .clr_warp  (wb_warp),
      .clr_reg   (wb_reg),
      .q_dst     (slot_dst),
      .q_src     (slot_src),
      .ops_ready (ops_ready)
   );

   ws_rr_pick #(
      .NW (NUM_WARPS)
   ) u_rr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (eligible),
      .adv     (take),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx)
   );

   // lane occupancy: a multi-cycle sweep, or always free when one pass covers the warp
   if (SWEEP > 1) begin : g_sweep
      lane_state_e      st_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LANE_IDLE;
            cnt_q <= '0;
         end else if (take) begin
            st_q  <= LANE_SWEEP;
            cnt_q <= CNT_W'(SWEEP - 1);
         end else if (st_q == LANE_SWEEP) begin
            if (cnt_q == CNT_W'(1)) begin
               st_q  <= LANE_IDLE;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end

      assign lane_free = (st_q == LANE_IDLE);
   end else begin : g_single
      assign lane_free = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid <= 1'b0;
         issue_warp  <= '0;
         issue_op    <= '0;
         issue_dst   <= '0;
      end else begin
         issue_valid <= take;
         if (take) begin
            issue_warp <= gnt_idx;
            issue_op   <= slot_op[gnt_idx*OP_W +: OP_W];
            issue_dst  <= take_dst;
         end
      end
   end

   // cycles since the last issue, saturating at the sweep length
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                    gap_q <= GAP_W'(SWEEP);
      else if (issue_valid)          gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(SWEEP)) gap_q <= gap_q + GAP_W'(1);
   end

   // R6: consecutive issues are a full sweep apart
   p_issue_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (gap_q >= GAP_W'(SWEEP)));

   // R2: an issued warp index is always a resident warp
   p_issue_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ({1'b0, issue_warp} < (WID_W+1)'(NUM_WARPS)));

endmodule

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;

   localparam int NW    = 24;
   localparam int WID_W = 5;
   localparam int TAG_W = 4;
   localparam int OP_W  = 16;
   localparam int SWEEP = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fill_valid = 1'b0;
   logic [WID_W-1:0]  fill_warp = '0;
   logic [OP_W-1:0]   fill_op = '0;
   logic [TAG_W-1:0]  fill_dst = '0;
   logic [2*TAG_W-1:0] fill_src = '0;
   logic              wb_valid = 1'b0;
   logic [WID_W-1:0]  wb_warp = '0;
   logic [TAG_W-1:0]  wb_reg = '0;
   logic              issue_valid;
   logic [WID_W-1:0]  issue_warp;
   logic [OP_W-1:0]   issue_op;
   logic [TAG_W-1:0]  issue_dst;

   always #2.5 clk = ~clk;

   warp_issue_sched u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_valid  (fill_valid),
      .fill_warp   (fill_warp),
      .fill_op     (fill_op),
      .fill_dst    (fill_dst),
      .fill_src    (fill_src),
      .wb_valid    (wb_valid),
      .wb_warp     (wb_warp),
      .wb_reg      (wb_reg),
      .issue_valid (issue_valid),
      .issue_warp  (issue_warp),
      .issue_op    (issue_op),
      .issue_dst   (issue_dst)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   int lw[$];
   int lc[$];
   int lo[$];
   int ld[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock edge; outputs sampled 1 ns after it and logged
   task automatic tick();
      @(posedge clk);
      #1;
      cyc++;
      if (issue_valid) begin
         lw.push_back(int'(issue_warp));
         lc.push_back(cyc);
         lo.push_back(int'(issue_op));
         ld.push_back(int'(issue_dst));
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic clear_log();
      lw.delete(); lc.delete(); lo.delete(); ld.delete();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ticks(3);
      rst_n = 1'b1;
      clear_log();
   endtask

   // source 0 in the low tag, source 1 above it
   task automatic do_fill(input int w, input int op, input int d, input int s0, input int s1);
      fill_valid = 1'b1;
      fill_warp  = WID_W'(w);
      fill_op    = OP_W'(op);
      fill_dst   = TAG_W'(d);
      fill_src   = {TAG_W'(s1), TAG_W'(s0)};
      tick();
      fill_valid = 1'b0;
   endtask

   task automatic do_wb(input int w, input int r);
      wb_valid = 1'b1;
      wb_warp  = WID_W'(w);
      wb_reg   = TAG_W'(r);
      tick();
      wb_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check(issue_valid == 1'b0, "R10 issue low after reset", int'(issue_valid), 0);
      ticks(6);
      check(lw.size() == 0, "R10 nothing issued from empty buffer", lw.size(), 0);
   endtask

   task automatic t_basic();
      int c;
      do_reset();
      do_fill(3, 'h1111, 5, 1, 2);
      c = cyc;
      ticks(1);
      check(lw.size() == 1, "R11 one issue after fill", lw.size(), 1);
      if (lw.size() == 1) begin
         check(lc[0] == c + 1, "R11 issue cycle", lc[0], c + 1);
         check(lw[0] == 3, "R2 issued warp", lw[0], 3);
         check(lo[0] == 'h1111, "R2 issued op", lo[0], 'h1111);
         check(ld[0] == 5, "R2 issued dst", ld[0], 5);
      end
      ticks(3);
      clear_log();
      // slot freed, so this fill is accepted; it reads reg 5 which is busy
      do_fill(3, 'h2222, 6, 5, 0);
      ticks(8);
      check(lw.size() == 0, "R8 reader of busy dst waits", lw.size(), 0);
      do_wb(3, 5);
      c = cyc;
      ticks(1);
      check(lw.size() == 1, "R4 issue after writeback", lw.size(), 1);
      if (lw.size() == 1) begin
         check(lc[0] == c + 1, "R4 issue one edge after writeback", lc[0], c + 1);
         check(lo[0] == 'h2222, "R2 second op of warp 3", lo[0], 'h2222);
      end
   endtask

   task automatic t_block();
      int c;
      // reg 6 of warp 3 is busy from t_basic; dst check (write after write)
      ticks(4);
      clear_log();
      do_fill(3, 'h3333, 6, 0, 0);
      ticks(6);
      check(lw.size() == 0, "R3 busy destination blocks", lw.size(), 0);
      do_fill(3, 'h4444, 1, 0, 0);
      do_wb(4, 6);
      ticks(6);
      check(lw.size() == 0, "R4 writeback of other warp has no effect", lw.size(), 0);
      do_wb(3, 6);
      c = cyc;
      ticks(10);
      check(lw.size() == 1, "R1 only the first fill was kept", lw.size(), 1);
      if (lw.size() >= 1) begin
         check(lo[0] == 'h3333, "R1 stored op unchanged", lo[0], 'h3333);
         check(lc[0] == c + 1, "R4 release timing", lc[0], c + 1);
      end
   endtask

   task automatic t_rr();
      int c;
      do_reset();
      do_fill(5, 'h0505, 1, 0, 0);
      c = cyc;
      do_fill(9, 'h0909, 1, 0, 0);
      do_fill(2, 'h0202, 1, 0, 0);
      ticks(12);
      check(lw.size() == 3, "R5 three issues", lw.size(), 3);
      if (lw.size() == 3) begin
         check(lw[0] == 5, "R5 first pick", lw[0], 5);
         check(lw[1] == 9, "R5 pick after pointer", lw[1], 9);
         check(lw[2] == 2, "R5 wrap to lower warp", lw[2], 2);
         check(lc[0] == c + 1, "R11 first issue cycle", lc[0], c + 1);
         check(lc[1] == lc[0] + SWEEP, "R6 second issue after sweep", lc[1] - lc[0], SWEEP);
         check(lc[2] == lc[1] + SWEEP, "R6 third issue after sweep", lc[2] - lc[1], SWEEP);
      end
   endtask

   task automatic t_full();
      int bad_order = 0;
      int bad_gap   = 0;
      do_reset();
      for (int w = 0; w < NW; w++) do_fill(w, 'h100 + w, 2, 0, 1);
      ticks(SWEEP * NW + 8);
      check(lw.size() == NW, "R7 every resident warp issued", lw.size(), NW);
      for (int i = 0; i < lw.size(); i++) begin
         if (lw[i] != i) bad_order++;
         if (i > 0 && lc[i] - lc[i-1] != SWEEP) bad_gap++;
      end
      check(bad_order == 0, "R5 full rotation order", bad_order, 0);
      check(bad_gap == 0, "R6 back-to-back spacing", bad_gap, 0);
   endtask

   task automatic t_collide();
      int c;
      do_reset();
      do_fill(7, 'h0707, 9, 0, 1);
      do_wb(7, 9);              // same edge as the issue of warp 7
      check(lw.size() == 1, "R9 issue in collision cycle", lw.size(), 1);
      ticks(4);
      clear_log();
      do_fill(7, 'h0777, 3, 9, 0);
      ticks(10);
      check(lw.size() == 0, "R9 register stays busy", lw.size(), 0);
      do_wb(7, 9);
      c = cyc;
      ticks(2);
      check(lw.size() == 1, "R9 later writeback releases", lw.size(), 1);
      if (lw.size() == 1) check(lc[0] == c + 1, "R4 release after collision", lc[0], c + 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_basic();
      t_block();
      t_rr();
      t_full();
      t_collide();
      finish_run();
   end

endmodule